// File: doc/BRIEF.md
# Signed Power-of-Two Rounding Divider

This unit divides a signed two's-complement word by 2^k, where the shift amount k arrives with each operand, and applies one of four rounding rules chosen per operand: floor, ceiling, truncation toward zero, or round to nearest with ties going away from zero. All four rules come from one arithmetic right shifter. A bias that depends on the mode, the shift amount and the operand's sign is added first, in an adder one bit wider than the operand. The shifted result is then caught in a single output register.

Operands enter on a valid/ready stream and quotients leave on another. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. A quotient is handed over on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the held quotient does not change and no new operand is taken. The shift amount must be below the data width.

Top module: `pow2_round_div`

## Requirements
- R1: With `in_mode` = 2'b00 (floor), the quotient is the largest integer not above in_data / 2^in_shift.
- R2: With `in_mode` = 2'b01 (ceiling), the quotient is the smallest integer not below in_data / 2^in_shift.
- R3: With `in_mode` = 2'b10 (truncate), the quotient is in_data / 2^in_shift rounded toward zero.
- R4: With `in_mode` = 2'b11 (nearest), the quotient magnitude is (|in_data| + 2^in_shift/2) / 2^in_shift rounded down, and it carries the sign of in_data. Halfway cases therefore round away from zero.
- R5: When `in_shift` is 0, `out_data` equals the accepted `in_data` in every mode.
- R6: Adding the bias never wraps. At the most positive and most negative operands, with the largest shift, every mode still gives the quotient from R1 to R4.
- R7: An operand accepted on a clock edge shows up on `out_valid`/`out_data` after that same edge, so one cycle later.
- R8: While `rst_n` is low at a clock edge (synchronous, active low), `out_valid` is cleared.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand will be accepted |
| in_data | input | DATA_W | Signed dividend |
| in_shift | input | SHIFT_W | Exponent k of the divisor 2^k, below DATA_W |
| in_mode | input | 2 | Rounding rule: 00 floor, 01 ceiling, 10 truncate, 11 nearest |
| out_valid | output | 1 | Quotient present |
| out_ready | input | 1 | Consumer accepts the quotient |
| out_data | output | DATA_W | Signed quotient |

## Verification
On every cycle, the assertions check the stream rules: one-cycle acceptance, the reset clear, and the held output under back-pressure. They also check that the bias sum keeps the operand's sign for non-negative operands and that the shifted value fits the output width. Identity at a zero shift is also checked on each accepted operand. The numeric rounding of each mode is shown only by the bench. It compares random and directed operands against integer-division reference functions, including ties, exact multiples and the extreme operand values.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    RND_FLOOR = 2'b00,
    RND_CEIL  = 2'b01,
    RND_TRUNC = 2'b10,
    RND_NEAR  = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rdiv_bias.sv
module rdiv_bias
  import rdiv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic              neg,
  input  logic [SHIFT_W-1:0] shift,
  input  rnd_mode_e         mode,
  output logic [DATA_W:0]   bias
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] one_w;
  logic [EXT_W-1:0] full_m1;   // 2^k - 1
  logic [EXT_W-1:0] half;      // 2^(k-1), zero when k is zero
  logic [EXT_W-1:0] half_m1;   // 2^(k-1) - 1, zero when k is zero

  assign one_w   = {{(EXT_W-1){1'b0}}, 1'b1};
  assign full_m1 = (one_w << shift) - one_w;
  assign half    = (shift == '0) ? '0 : (one_w << (shift - 1'b1));
  assign half_m1 = (shift == '0) ? '0 : (half - one_w);

  // Nearest mode on a negative operand must subtract half and then
  // truncate; expressed through the floor shifter this is a bias of
  // (2^k - 1) - 2^(k-1) = 2^(k-1) - 1.
  always_comb begin
    unique case (mode)
      RND_FLOOR: bias = '0;
      RND_CEIL:  bias = full_m1;
      RND_TRUNC: bias = neg ? full_m1 : '0;
      RND_NEAR:  bias = neg ? half_m1 : half;
      default:   bias = '0;
    endcase
  end
endmodule

// File: rtl/rdiv_shifter.sv
module rdiv_shifter #(
  parameter int WIDTH   = 17,
  parameter int SHIFT_W = 4
) (
  input  logic [WIDTH-1:0]   x,
  input  logic [SHIFT_W-1:0] shift,
  output logic [WIDTH-1:0]   y
);
  logic [WIDTH-1:0] stage [0:SHIFT_W];

  assign stage[0] = x;

  // Logarithmic barrel: stage i moves right by 2^i, filling with the sign.
  for (genvar i = 0; i < SHIFT_W; i++) begin : g_stage
    localparam int AMT = 1 << i;
    assign stage[i+1] = shift[i]
      ? {{AMT{stage[i][WIDTH-1]}}, stage[i][WIDTH-1:AMT]}
      : stage[i];
  end

  assign y = stage[SHIFT_W];
endmodule

// File: rtl/rdiv_stage.sv
module rdiv_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);  // R7

  AST_RESET_CLR: assert property (@(posedge clk)
    !rst_n |=> !out_valid);  // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R9
endmodule

// File: rtl/pow2_round_div.sv
module pow2_round_div
  import rdiv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHIFT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [1:0]         in_mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);
  localparam int EXT_W = DATA_W + 1;

  rnd_mode_e        mode;
  logic             neg;
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] bias;
  logic [EXT_W-1:0] sum;
  logic [EXT_W-1:0] shifted;
  logic [DATA_W-1:0] quot;

  assign mode = rnd_mode_e'(in_mode);
  assign neg  = in_data[DATA_W-1];
  assign ext  = {neg, in_data};

  rdiv_bias #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) bias_i (
    .neg   (neg),
    .shift (in_shift),
    .mode  (mode),
    .bias  (bias)
  );

  // One bit of headroom: the largest operand plus the largest bias stays
  // below 2^DATA_W, so the signed extended sum cannot wrap.
  assign sum = ext + bias;

  rdiv_shifter #(.WIDTH(EXT_W), .SHIFT_W(SHIFT_W)) shift_i (
    .x     (sum),
    .shift (in_shift),
    .y     (shifted)
  );

  assign quot = shifted[DATA_W-1:0];

  rdiv_stage #(.DATA_W(DATA_W)) stage_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (quot),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !neg) |-> !sum[EXT_W-1]);  // R6

  AST_FITS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (shifted[EXT_W-1] == shifted[DATA_W-1]));  // R6

  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_shift == '0) |=> (out_data == $past(in_data)));  // R5
endmodule

// File: tb/pow2_round_div_tb_top.sv
`timescale 1ns/1ps
module pow2_round_div_tb_top;
  localparam int DW = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [SW-1:0] in_shift = '0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pow2_round_div #(.DATA_W(DW), .SHIFT_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_shift(in_shift), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic longint ref_q(longint a, int k, int m);
    longint d, t, mag;
    d = longint'(1) << k;
    t = a / d;
    case (m)
      0: return (a < 0 && (a % d) != 0) ? t - 1 : t;
      1: return (a > 0 && (a % d) != 0) ? t + 1 : t;
      2: return t;
      default: begin
        mag = ((a < 0 ? -a : a) + d / 2) / d;
        return (a < 0) ? -mag : mag;
      end
    endcase
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sval(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  // Drive one operand at a falling edge, check it at the next falling edge.
  task automatic run_one(longint a, int k, int m, string req);
    in_valid = 1'b1;
    in_data  = a[DW-1:0];
    in_shift = k[SW-1:0];
    in_mode  = m[1:0];
    @(negedge clk);
    check({req, " R7 valid"}, longint'(out_valid), 1);
    check(req, sval(out_data), ref_q(a, k, m));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    longint a, hold_exp;
    int k, m;
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check("R8 reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle", longint'(out_valid), 0);

    // Directed: ties, exact multiples, signs.
    run_one(6, 2, 0, "R1");
    run_one(-6, 2, 0, "R1");
    run_one(6, 2, 1, "R2");
    run_one(-6, 2, 1, "R2");
    run_one(-7, 2, 2, "R3");
    run_one(7, 2, 2, "R3");
    run_one(6, 2, 3, "R4 tie+");
    run_one(-6, 2, 3, "R4 tie-");
    run_one(-5, 2, 3, "R4");
    run_one(-8, 3, 1, "R2 exact");
    // R5: zero shift is identity in every mode.
    for (int mm = 0; mm < 4; mm++) begin
      run_one(-12345, 0, mm, "R5");
      run_one(32767, 0, mm, "R5");
    end
    // R6: extremes with the largest shift and a mid shift.
    for (int mm = 0; mm < 4; mm++) begin
      run_one(32767, 15, mm, "R6");
      run_one(-32768, 15, mm, "R6");
      run_one(32767, 1, mm, "R6");
      run_one(-32768, 1, mm, "R6");
      run_one(-1, 15, mm, "R6");
    end
    // Random operands, back to back.
    for (int i = 0; i < 400; i++) begin
      a = longint'($signed(16'($urandom())));
      k = int'($urandom_range(0, 15));
      m = int'($urandom_range(0, 3));
      run_one(a, k, m, req_of(m));
    end

    // R9: back-pressure.
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 drain", longint'(out_valid), 0);
    out_ready = 1'b0;
    run_one(-13, 2, 3, "R4");
    hold_exp = ref_q(-13, 2, 3);
    in_data = 16'd100;
    in_shift = 4'd1;
    in_mode = 2'b01;
    check("R9 in_ready", longint'(in_ready), 0);
    @(negedge clk);
    check("R9 hold", sval(out_data), hold_exp);
    check("R9 in_ready", longint'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 resume", sval(out_data), ref_q(100, 1, 1));
    in_valid = 1'b0;
    @(negedge clk);

    // R8: reset clears a full output.
    run_one(5, 1, 0, "R1");
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 clear", longint'(out_valid), 0);
    finish_run();
  end
endmodule